// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM. The RAM holds 2048K words of 16 bits each and has two byte lanes. The host issues one word request at a time through a valid/ready handshake. A request carries a write flag, a word address, write data and a per-lane byte mask.

The block turns each request into a strobe sequence on the memory side:
- chip select, write strobe and read strobe, all active low;
- one active-low strobe per byte lane;
- the held address;
- the write data, with a drive enable for the pad.

Every phase length is counted in clock cycles. Each count is derived from a nanosecond-class minimum, given in picoseconds, and a clock-period parameter, rounded up to whole cycles and never less than one cycle.

After reset, no access is accepted until a power-up interval has elapsed. By default this interval is 150 us. Between accesses, chip select stays high so that the RAM sits in standby. Read data comes back as a one-cycle response pulse. Byte lanes that the mask did not enable are returned as zero.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held, and directly after it, chip select, write strobe, read strobe and both lane strobes are high, the data drive enable is low, and req_ready is low.
- R2: req_ready stays low for exactly ceil(PWRUP_PS/CLK_PS) clock edges after reset is released. A request presented during that interval causes no memory activity.
- R3: A write holds chip select and write strobe low, with the read strobe high, for N_WP consecutive cycles. During those cycles mem_addr equals the request address and mem_dq_o equals the request data.
- R4: mem_dq_oe is high during every write-strobe-low cycle and for exactly one further cycle after that, which gives N_WP+1 cycles per write. It is low at all other times.
- R5: A read holds chip select and read strobe low, with the write strobe high, for N_RD consecutive cycles. N_RD is the largest of the rounded-up read cycle time, address access time and read-strobe access time.
- R6: rsp_valid pulses for one cycle right after the read phase ends. rsp_rdata carries the sampled word, with each byte lane whose mask bit is 0 forced to zero.
- R7: Mask bit 0 drives lane strobe bit 0, which covers data bits 7:0. Mask bit 1 drives lane strobe bit 1, which covers bits 15:8. A lane strobe is low during an access only when its mask bit is 1, so a write leaves the unmasked byte of the stored word unchanged.
- R8: mem_dq_oe is never high in a cycle where the read strobe is low. It is also low in the cycle just before any cycle in which the read strobe falls.
- R9: req_ready is high only while the block is idle and power-up is complete. Whenever req_ready is high, chip select is high. req_ready drops in the cycle after a request is accepted.
- R10: N_WP is the largest of the rounded-up write-strobe width, the rounded-up data setup time, and the rounded-up write cycle time minus one. With a 10 ns clock, a 18 ns strobe width, a 6 ns setup and a 35 ns cycle, N_WP is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_lane_n | output | 2 | Byte lane strobes, active low |
| mem_addr | output | 21 | Memory address |
| mem_dq_o | output | 16 | Data to the pad |
| mem_dq_oe | output | 1 | Pad drive enable |
| mem_dq_i | input | 16 | Data from the pad |

## Verification
The bench keeps the 10 ns clock and makes three changes to the parameters:
- The power-up interval is cut to 2 us, which is 200 cycles, so the bench can count the whole hold-off edge by edge.
- The access time is raised to 25 ns, which stretches reads to three cycles.
- The strobe width is raised to 18 ns and the write cycle to 35 ns, which stretches writes to three strobe cycles plus one hold cycle.

With these multi-cycle phases, rounding up, the max selection between the timing terms, and the bus release before a read become visible as exact strobe run lengths. A behavioural RAM model in the bench exposes lane masking and read-after-write ordering.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_WRH  = 2'd3
  } seq_state_t;

  // whole cycles covering t_ps at period clk_ps, never below one
  function automatic int cyc_ceil(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_pwrup_wait.sv
module sram_pwrup_wait #(
  parameter int N_PU = 15000
) (
  input  logic clk,
  input  logic rst_n,
  output logic pwr_done
);
  localparam int CW = $clog2(N_PU + 1);

  logic [CW-1:0] cnt_q;

  assign pwr_done = (cnt_q == CW'(N_PU));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!pwr_done) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  assign done = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (!done) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int TW     = 2,
  parameter int N_RD   = 1,
  parameter int N_WP   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_done,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_lane_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  seq_state_t        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] lane_bits;
  logic              accept;
  logic              busy;

  assign req_ready = (st_q == ST_IDLE) && pwr_done;
  assign accept    = req_valid && req_ready;
  assign busy      = (st_q == ST_RD) || (st_q == ST_WR);

  always_comb begin
    for (int l = 0; l < LANES; l++)
      lane_bits[l*8 +: 8] = {8{mask_q[l]}};
  end

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (req_write) begin
          st_d    = ST_WR;
          tmr_val = TW'(N_WP - 1);
        end else begin
          st_d    = ST_RD;
          tmr_val = TW'(N_RD - 1);
        end
      end
      ST_RD:   if (tmr_done) st_d = ST_IDLE;
      ST_WR:   if (tmr_done) st_d = ST_WRH;
      ST_WRH:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      mask_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st_q      <= st_d;
      rsp_valid <= 1'b0;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= req_mask;
      end
      if (st_q == ST_RD && tmr_done) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= mem_dq_i & lane_bits;
      end
    end
  end

  assign mem_cs_n   = !busy;
  assign mem_we_n   = (st_q != ST_WR);
  assign mem_oe_n   = (st_q != ST_RD);
  assign mem_lane_n = busy ? ~mask_q : '1;
  assign mem_addr   = addr_q;
  assign mem_dq_o   = wdata_q;
  assign mem_dq_oe  = (st_q == ST_WR) || (st_q == ST_WRH);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 16,
  parameter int CLK_PS    = 10000,
  parameter int PWRUP_PS  = 150000000,
  parameter int T_RC_PS   = 10000,
  parameter int T_AA_PS   = 10000,
  parameter int T_DOE_PS  = 6000,
  parameter int T_WC_PS   = 10000,
  parameter int T_PWE_PS  = 8000,
  parameter int T_SD_PS   = 6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W/8-1:0] mem_lane_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int LANES = DATA_W / 8;
  localparam int N_PU  = cyc_ceil(PWRUP_PS, CLK_PS);
  localparam int N_RD  = imax(imax(cyc_ceil(T_RC_PS, CLK_PS), cyc_ceil(T_AA_PS, CLK_PS)),
                              cyc_ceil(T_DOE_PS, CLK_PS));
  localparam int N_WP  = imax(imax(cyc_ceil(T_PWE_PS, CLK_PS), cyc_ceil(T_SD_PS, CLK_PS)),
                              cyc_ceil(T_WC_PS, CLK_PS) - 1);
  localparam int TW    = imax($clog2(imax(N_RD, N_WP) + 1), 1);

  logic          pwr_done;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_done;

  sram_pwrup_wait #(.N_PU(N_PU)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_done (pwr_done)
  );

  sram_phase_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_seq #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LANES (LANES),
    .TW     (TW),     .N_RD   (N_RD),   .N_WP  (N_WP)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_done   (pwr_done),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_lane_n (mem_lane_n),
    .mem_addr   (mem_addr),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_i   (mem_dq_i)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_done,
  input logic req_ready,
  input logic rsp_valid,
  input logic mem_cs_n,
  input logic mem_we_n,
  input logic mem_oe_n,
  input logic mem_dq_oe
);
  // R9: idle handshake implies standby
  p_ready_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n);

  // R2: no acceptance before the power-up count finishes
  p_ready_after_pwrup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> pwr_done);

  // R8: pad never driven while the read strobe is low
  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R8: bus released the cycle before a read strobe falls
  p_release_before_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R3: write strobe only with chip select low and read strobe high
  p_write_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));

  // R4: data is driven whenever the write strobe is low
  p_drive_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  // R4: drive ends one cycle after the write strobe rises
  p_drive_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !mem_dq_oe);

  // R6: response is a single-cycle pulse
  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind sram_ctrl sram_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_done  (pwr_done),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
  localparam int CLK_PS  = 10000;
  localparam int PU_PS   = 2000000;
  localparam int EXP_PU  = (PU_PS + CLK_PS - 1) / CLK_PS;   // 200
  localparam int EXP_RD  = 3;   // ceil(25ns/10ns)
  localparam int EXP_WP  = 3;   // max(ceil(18/10)=2, ceil(6/10)=1, ceil(35/10)-1=3)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [20:0] mem_addr;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5ns clk = ~clk;

  sram_ctrl #(
    .CLK_PS (CLK_PS), .PWRUP_PS (PU_PS),
    .T_RC_PS (10000), .T_AA_PS (25000), .T_DOE_PS (6000),
    .T_WC_PS (35000), .T_PWE_PS (18000), .T_SD_PS (6000)
  ) u0 (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata), .req_mask (req_mask),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .mem_cs_n (mem_cs_n), .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n),
    .mem_lane_n (mem_lane_n), .mem_addr (mem_addr), .mem_dq_o (mem_dq_o),
    .mem_dq_oe (mem_dq_oe), .mem_dq_i (mem_dq_i)
  );

  // behavioural RAM, 64 words indexed by the low address bits
  logic [15:0] ram [64];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) ram[i] <= 16'h0000;
    end else if (!mem_cs_n && !mem_we_n) begin
      if (!mem_lane_n[0]) ram[mem_addr[5:0]][7:0]  <= mem_dq_o[7:0];
      if (!mem_lane_n[1]) ram[mem_addr[5:0]][15:8] <= mem_dq_o[15:8];
    end
  end
  always_comb begin
    if (!mem_cs_n && mem_we_n && !mem_oe_n)
      mem_dq_i = {mem_lane_n[1] ? 8'hA5 : ram[mem_addr[5:0]][15:8],
                  mem_lane_n[0] ? 8'h5A : ram[mem_addr[5:0]][7:0]};
    else
      mem_dq_i = 16'hDEAD;
  end

  // monitor: strobe run lengths and values seen inside strobes
  int we_run = 0, we_last = 0, oe_run = 0, oe_last = 0, dr_run = 0, dr_last = 0;
  int contention = 0, ready_busy = 0, cs_activity = 0;
  logic [1:0]  w_lane, r_lane;
  logic [20:0] w_addr;
  logic [15:0] w_dq;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n) begin
        we_run++; w_lane = mem_lane_n; w_addr = mem_addr; w_dq = mem_dq_o;
      end else if (we_run > 0) begin we_last = we_run; we_run = 0; end
      if (!mem_oe_n) begin oe_run++; r_lane = mem_lane_n; end
      else if (oe_run > 0) begin oe_last = oe_run; oe_run = 0; end
      if (mem_dq_oe) dr_run++;
      else if (dr_run > 0) begin dr_last = dr_run; dr_run = 0; end
      if (mem_dq_oe && !mem_oe_n) contention++;
      if (req_ready && !mem_cs_n) ready_busy++;
      if (!mem_cs_n) cs_activity++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [20:0] a,
                       input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 ready after accept", req_ready, 0);
  endtask

  task automatic do_write(input logic [20:0] a, input logic [15:0] d, input logic [1:0] m);
    issue(1'b1, a, d, m);
    repeat (6) @(negedge clk);
    chk(we_last == EXP_WP, "R3/R10 write strobe cycles", we_last, EXP_WP);
    chk(dr_last == EXP_WP + 1, "R4 drive cycles", dr_last, EXP_WP + 1);
    chk(w_addr == a && w_dq == d, "R3 addr/data", {w_addr, w_dq}, {a, d});
    chk(w_lane == ~m, "R7 write lane strobes", w_lane, ~m);
  endtask

  task automatic do_read(input logic [20:0] a, input logic [1:0] m, input logic [15:0] exp);
    int n;
    issue(1'b0, a, 16'h0, m);
    n = 0;
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    chk(rsp_valid, "R6 response", rsp_valid, 1);
    chk(rsp_rdata == exp, "R6 read data", rsp_rdata, exp);
    @(negedge clk);
    chk(!rsp_valid, "R6 single pulse", rsp_valid, 0);
    chk(oe_last == EXP_RD, "R5 read strobe cycles", oe_last, EXP_RD);
    chk(r_lane == ~m, "R7 read lane strobes", r_lane, ~m);
  endtask

  task automatic t_reset;
    #3ns;
    chk(mem_cs_n && mem_we_n && mem_oe_n && mem_lane_n == 2'b11,
        "R1 strobes in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n}, 5'h1f);
    chk(!mem_dq_oe && !req_ready, "R1 drive/ready in reset", {mem_dq_oe, req_ready}, 0);
  endtask

  task automatic t_pwrup;
    int edges;
    @(negedge clk);
    rst_n = 1'b1;
    chk(mem_cs_n && !mem_dq_oe && !req_ready, "R1 after release",
        {mem_cs_n, mem_dq_oe, req_ready}, 4);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 21'd9; req_wdata = 16'hBEEF; req_mask = 2'b11;
    edges = 0;
    while (!req_ready && edges < 1000) begin @(negedge clk); edges++; end
    req_valid = 1'b0;
    chk(edges == EXP_PU, "R2 power-up edges", edges, EXP_PU);
    chk(cs_activity == 0, "R2 no access during power-up", cs_activity, 0);
  endtask

  initial begin
    t_reset();
    t_pwrup();
    do_write(21'd5, 16'h1234, 2'b11);
    do_read(21'd5, 2'b11, 16'h1234);
    do_write(21'd5, 16'hABCD, 2'b01);
    do_read(21'd5, 2'b11, 16'h12CD);          // R7 upper byte kept
    do_read(21'd5, 2'b10, 16'h1200);          // R6 lower lane zeroed
    do_write(21'h1FFFFF, 16'h55AA, 2'b10);
    do_read(21'h1FFFFF, 2'b11, 16'h5500);     // R7 lower byte untouched
    do_read(21'h1FFFFF, 2'b01, 16'h0000);
    chk(contention == 0, "R8 drive during read", contention, 0);
    chk(ready_busy == 0, "R9 ready while selected", ready_busy, 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule